// File: doc/BRIEF.md
# Dual-Strobe Reversible Counter

This block is a small reversible binary counter with no direction pin. Two separate strobe inputs set the direction. A rising strobe on the up input, while the down input rests high, adds one. A rising strobe on the down input, while the up input rests high, subtracts one. Every bit of the count changes on the same system clock edge. A preset path loads a parallel value, and a clear input zeroes the count. Clear wins over preset, and preset wins over counting.

The strobes can come from anywhere, so a single system clock samples them through a two-flop synchroniser per strobe and detects their rising edges there. Preset and clear are sampled directly, and they take effect on the next clock edge.

Two active-low terminal outputs let stages chain with no extra logic. The carry output goes low while the count is at its maximum and the synchronised up strobe is low. The borrow output goes low while the count is zero and the synchronised down strobe is low. A user wires carry to the next stage's up strobe and borrow to its down strobe. Each terminal output then rises exactly once per wrap, and that rise is the next stage's count edge.

Top module: `dual_strobe_counter`

## Requirements
- R1: While `rst` is high, and after it is released, the count is 0 and both `carry_n` and `borrow_n` are 1.
- R2: A low-to-high transition of `inc_strb` while `dec_strb` is high adds one to `cnt_q`. The new count appears by the third system clock edge after the first edge that samples the strobe high, and the count wraps from 15 to 0.
- R3: A low-to-high transition of `dec_strb` while `inc_strb` is high subtracts one from `cnt_q`, with the same latency as R2, and the count wraps from 0 to 15.
- R4: The count does not change in either of these cases:
  - both strobes rise in the same sampling cycle;
  - one strobe rises while the other strobe is held low.
- R5: On every clock edge that samples `load_n` low (with `clr` low), `cnt_q` takes the value of `preset_val`, and strobe edges have no effect.
- R6: On every clock edge that samples `clr` high, `cnt_q` becomes 0, whatever `load_n` and the strobes are doing.
- R7: `carry_n` is 0 exactly when `cnt_q` is 15 (all ones) and `inc_strb`, delayed by two synchronising clocks, is low. Otherwise `carry_n` is 1.
- R8: `borrow_n` is 0 exactly when `cnt_q` is 0 and `dec_strb`, delayed by two synchronising clocks, is low. Otherwise `borrow_n` is 1.
- R9: Two stages chained as described above (low stage `carry_n` to high stage `inc_strb`, low stage `borrow_n` to high stage `dec_strb`) behave as one 8-bit counter:
  - counting up runs through every value from 0 to 255 and wraps to 0;
  - counting down runs from 0 through 255 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| inc_strb | input | 1 | Up-count strobe; its rising edge counts up |
| dec_strb | input | 1 | Down-count strobe; its rising edge counts down |
| load_n | input | 1 | Active-low preset enable |
| preset_val | input | CNT_W | Value loaded while `load_n` is low |
| clr | input | 1 | Active-high clear, highest priority |
| cnt_q | output | CNT_W | Current count |
| carry_n | output | 1 | Active-low carry pulse at the all-ones count |
| borrow_n | output | 1 | Active-low borrow pulse at zero count |

## Verification
The hardest case to reach from the ports is the carry or borrow of a lower stage producing exactly one clean count edge in an upper stage. This only happens at a wrap, after a full sweep of the lower nibble, and it depends on how the terminal pulse lines up with the synchroniser delay.

The bench chains two instances. It drives a full 0 to 255 sweep up and a full sweep back down, and checks the combined byte after every strobe.

Before that, it covers the single-stage cases exhaustively:
- a load of every preset value;
- wraps in both directions;
- simultaneous strobes;
- strobes against a held-low partner;
- clear against an active load.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int STROBE_UP = 0;
    localparam int STROBE_DN = 1;
    localparam int N_STROBES = 2;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_INC,
        ACT_DEC,
        ACT_LOAD,
        ACT_CLEAR
    } cnt_action_e;

    typedef struct packed {
        logic lvl;
        logic rise;
    } strobe_view_t;

    // Priority: clear, then preset, then a lone strobe edge with its partner high.
    function automatic cnt_action_e pick_action(
        input logic         clr,
        input logic         load_n,
        input strobe_view_t up,
        input strobe_view_t dn
    );
        if (clr)                                 return ACT_CLEAR;
        else if (!load_n)                        return ACT_LOAD;
        else if (up.rise && !dn.rise && dn.lvl)  return ACT_INC;
        else if (dn.rise && !up.rise && up.lvl)  return ACT_DEC;
        else                                     return ACT_HOLD;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import dsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe_in,
    output strobe_view_t view
);
    // pipe[SYNC_STAGES-1] is the usable level, pipe[SYNC_STAGES] its previous value.
    logic [SYNC_STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[SYNC_STAGES-1:0], strobe_in};
    end

    always_comb begin
        view.lvl  = pipe[SYNC_STAGES-1];
        view.rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
    end
endmodule

// File: rtl/count_core.sv
module count_core
    import dsc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_action_e       act,
    input  logic [CNT_W-1:0]  preset,
    output logic [CNT_W-1:0]  q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: q <= '0;
                ACT_LOAD:  q <= preset;
                ACT_INC:   q <= q + ONE;
                ACT_DEC:   q <= q - ONE;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/term_decode.sv
module term_decode #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] q,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_comb begin
        carry_n  = ~((q == TOP) & ~up_lvl);
        borrow_n = ~((q == '0)  & ~dn_lvl);
    end
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
    import dsc_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_strb,
    input  logic             dec_strb,
    input  logic             load_n,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             carry_n,
    output logic             borrow_n
);
    logic [N_STROBES-1:0] raw_strb;
    strobe_view_t         views [N_STROBES];
    cnt_action_e          action;

    always_comb begin
        raw_strb            = '0;
        raw_strb[STROBE_UP] = inc_strb;
        raw_strb[STROBE_DN] = dec_strb;
    end

    for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
        strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst       (rst),
            .strobe_in (raw_strb[g]),
            .view      (views[g])
        );
    end

    always_comb action = pick_action(clr, load_n, views[STROBE_UP], views[STROBE_DN]);

    count_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .act    (action),
        .preset (preset_val),
        .q      (cnt_q)
    );

    term_decode #(.CNT_W(CNT_W)) u_term (
        .q        (cnt_q),
        .up_lvl   (views[STROBE_UP].lvl),
        .dn_lvl   (views[STROBE_DN].lvl),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             load_n,
    input logic [CNT_W-1:0] preset_val,
    input logic [CNT_W-1:0] cnt_q,
    input logic             carry_n,
    input logic             borrow_n
);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r1_reset_zero: assert property (@(posedge clk) rst |=> cnt_q == '0);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);

    a_r5_load_value: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_n) |=> cnt_q == $past(preset_val));

    // R2 and R3: outside clear and load the count moves by at most one step.
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n) |=> (cnt_q == $past(cnt_q))
                          || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))
                          || (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    a_r7_carry_at_top: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> cnt_q == TOP);

    a_r8_borrow_at_zero: assert property (@(posedge clk) disable iff (rst)
        !borrow_n |-> cnt_q == '0);
endmodule

bind dual_strobe_counter dsc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .load_n     (load_n),
    .preset_val (preset_val),
    .cnt_q      (cnt_q),
    .carry_n    (carry_n),
    .borrow_n   (borrow_n)
);

// File: tb/dual_strobe_counter_test.sv
module dual_strobe_counter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inc_strb = 1'b1;
    logic       dec_strb = 1'b1;
    logic       load_n = 1'b1;
    logic       clr = 1'b0;
    logic [3:0] preset_val = 4'd0;
    logic [3:0] preset_hi = 4'd0;
    logic [3:0] cnt_lo, cnt_hi;
    logic       carry_lo, borrow_lo, carry_hi, borrow_hi;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    dual_strobe_counter uut (
        .clk(clk), .rst(rst), .inc_strb(inc_strb), .dec_strb(dec_strb),
        .load_n(load_n), .preset_val(preset_val), .clr(clr),
        .cnt_q(cnt_lo), .carry_n(carry_lo), .borrow_n(borrow_lo)
    );

    dual_strobe_counter uut_hi (
        .clk(clk), .rst(rst), .inc_strb(carry_lo), .dec_strb(borrow_lo),
        .load_n(load_n), .preset_val(preset_hi), .clr(clr),
        .cnt_q(cnt_hi), .carry_n(carry_hi), .borrow_n(borrow_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_up();
        inc_strb = 1'b0; cyc(4);
        inc_strb = 1'b1; cyc(8);
    endtask

    task automatic pulse_down();
        dec_strb = 1'b0; cyc(4);
        dec_strb = 1'b1; cyc(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        check("R1 count in reset", int'(cnt_lo), 0);
        rst = 1'b0;
        cyc(2);
        check("R1 count", int'(cnt_lo), 0);
        check("R1 carry_n", int'(carry_lo), 1);
        check("R1 borrow_n", int'(borrow_lo), 1);

        // R2: count up with wrap
        for (int i = 1; i <= 20; i++) begin
            pulse_up();
            check("R2 up count", int'(cnt_lo), i % 16);
        end
        // R3: count down with wrap (starts at 4)
        for (int i = 1; i <= 20; i++) begin
            pulse_down();
            check("R3 down count", int'(cnt_lo), (((4 - i) % 16) + 16) % 16);
        end

        // R5: exhaustive preset, strobe ignored while loading
        for (int v = 0; v < 16; v++) begin
            preset_val = 4'(v);
            load_n = 1'b0; cyc(2);
            check("R5 load value", int'(cnt_lo), v);
            load_n = 1'b1; cyc(1);
        end
        preset_val = 4'd9; load_n = 1'b0; cyc(2);
        pulse_up();
        check("R5 strobe ignored during load", int'(cnt_lo), 9);
        pulse_down();
        check("R5 down strobe ignored during load", int'(cnt_lo), 9);
        preset_val = 4'd15; cyc(2);
        load_n = 1'b1; cyc(2);
        check("R5 value held after load", int'(cnt_lo), 15);

        // R7: carry at 15
        check("R7 carry_n high with up high", int'(carry_lo), 1);
        inc_strb = 1'b0; cyc(4);
        check("R7 carry_n low at 15", int'(carry_lo), 0);
        check("R8 borrow_n high at 15", int'(borrow_lo), 1);
        inc_strb = 1'b1; cyc(8);
        check("R2 wrap to 0", int'(cnt_lo), 0);
        check("R7 carry_n released", int'(carry_lo), 1);
        // R8: borrow at 0
        dec_strb = 1'b0; cyc(4);
        check("R8 borrow_n low at 0", int'(borrow_lo), 0);
        dec_strb = 1'b1; cyc(8);
        check("R3 wrap to 15", int'(cnt_lo), 15);
        check("R8 borrow_n released", int'(borrow_lo), 1);
        pulse_up();
        inc_strb = 1'b0; cyc(4);
        check("R7 carry_n high when count is 0", int'(carry_lo), 1);
        inc_strb = 1'b1; cyc(8);
        check("R2 count 1", int'(cnt_lo), 1);

        // R4: simultaneous edges, and edge against a held-low partner
        inc_strb = 1'b0; dec_strb = 1'b0; cyc(4);
        inc_strb = 1'b1; dec_strb = 1'b1; cyc(8);
        check("R4 both strobes rise", int'(cnt_lo), 1);
        dec_strb = 1'b0; cyc(4);
        pulse_up();
        check("R4 up edge with down low", int'(cnt_lo), 1);
        dec_strb = 1'b1; cyc(8);
        check("R3 down edge after hold", int'(cnt_lo), 0);
        inc_strb = 1'b0; cyc(4);
        pulse_down();
        check("R4 down edge with up low", int'(cnt_lo), 0);
        inc_strb = 1'b1; cyc(8);
        check("R2 up edge after hold", int'(cnt_lo), 1);

        // R6: clear beats load and strobes
        preset_val = 4'd7; load_n = 1'b0; cyc(2);
        check("R5 load 7", int'(cnt_lo), 7);
        clr = 1'b1; cyc(2);
        check("R6 clear over load", int'(cnt_lo), 0);
        load_n = 1'b1;
        pulse_up();
        check("R6 clear over strobe", int'(cnt_lo), 0);
        clr = 1'b0; cyc(2);
        check("R6 zero after clear", int'(cnt_lo), 0);

        // R9: two-stage chain, full sweep up and back down
        clr = 1'b1; cyc(2);
        clr = 1'b0; cyc(2);
        check("R9 chain cleared", int'({cnt_hi, cnt_lo}), 0);
        for (int i = 1; i <= 256; i++) begin
            pulse_up();
            check("R9 chain up", int'({cnt_hi, cnt_lo}), i % 256);
        end
        for (int i = 1; i <= 256; i++) begin
            pulse_down();
            check("R9 chain down", int'({cnt_hi, cnt_lo}), (256 - i) % 256);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule